// File: doc/BRIEF.md
# Channel-Partitioned Audio Transmit Sample FIFO

This block buffers outgoing audio samples between a register bus and a serial audio transmitter. Software writes 24-bit samples through a data register. A serializer removes one sample for each channel slot it sends. All channels share one storage array of fixed word depth, so the number of whole frames the queue can hold shrinks as the configured channel count grows. Software sees the fill level in frames, not words.

A small control register empties the queue on request and enables an interrupt request. The request is raised while the frame level sits at or below half of the current frame capacity, so software can refill in bursts. A status register holds the frame occupancy and two sticky error flags: one for a sample written while the queue is full, one for a sample requested while the queue is empty. Register selects are 0 for control, 1 for status and 2 for sample data. Select 3 reads as zero and ignores writes.

Top module: `tx_sample_fifo`

## Requirements
- R1: With the default 256-word array, the frame capacity is 256 for 1 channel, 128 for 2, 64 for 3 or 4, and 32 for 5 to 8. The queue accepts exactly frame capacity times channel count words written to select 2.
- R2: A channel count input of 0 or of 9 to 15 behaves exactly as 8 channels. Moving between two inputs with the same effective count leaves the queue contents in place.
- R3: Only bits 23:0 of a written sample are stored, and samples leave in write order on `pop_data_o`. While the queue is empty, `pop_valid_o` is 0 and `pop_data_o` is 0.
- R4: Status bits 16:8 hold the occupancy in frames. This is the number of complete frames written minus the number of complete frames popped since the last empty-out.
- R5: A sample written while the queue is full is discarded and sets the sticky overrun flag at status bit 4.
- R6: A pop requested while the queue is empty changes no contents and sets the sticky underrun flag at status bit 0.
- R7: Writing 1 to status bit 4 or to status bit 0 clears that flag. Writing 0 leaves it set.
- R8: Writing 1 to control bit 0 empties the queue on that clock edge. This bit always reads back as 0.
- R9: A change of the effective channel count empties the queue.
- R10: Control bit 20 is a readable interrupt enable. `irq_o` is high exactly when it is set and the frame occupancy is at or below half the frame capacity.
- R11: After reset the queue is empty, both flags and the enable are 0, and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_chans | input | 4 | Channel count per frame (0 and 9..15 mean 8) |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| pop_i | input | 1 | Serializer takes the head sample |
| pop_data_o | output | 24 | Head sample, zero when empty |
| pop_valid_o | output | 1 | Queue holds at least one sample |
| irq_o | output | 1 | Half-level refill request |

## Verification
The hardest situation to reach is the true full boundary for every channel count. Word capacity is 192 for three channels and 160 for five, not the array size, so the overrun edge moves with the configuration. The stimulus sweeps every count from 1 to 8, plus the out-of-range codes, and fills the queue word by word. It computes the frame occupancy and the interrupt level arithmetically after every single write and pop. At the full point it pushes one extra sample to catch the overrun, and once drained it pops once more to catch the underrun.

// File: rtl/tx_sample_fifo_pkg.sv
package tx_sample_fifo_pkg;

   // register selects on reg_addr
   typedef enum logic [1:0] {
      SEL_CTRL = 2'd0,
      SEL_STAT = 2'd1,
      SEL_DATA = 2'd2,
      SEL_NONE = 2'd3
   } reg_sel_e;

   // bit positions software depends on
   localparam int CLR_BIT     = 0;
   localparam int HALF_IE_BIT = 20;
   localparam int UNDER_BIT   = 0;
   localparam int OVER_BIT    = 4;
   localparam int OCC_LSB     = 8;
   localparam int OCC_W       = 9;

endpackage

// File: rtl/tx_sample_fifo_chcfg.sv
module tx_sample_fifo_chcfg #(
   parameter int MAX_CH = 8,
   parameter int DEPTH  = 256,
   parameter int CHW    = 4,
   parameter int CW     = 9
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [CHW-1:0] cfg_chans_i,
   output logic [CHW-1:0] chans_o,
   output logic [CW-1:0]  frame_cap_o,
   output logic [CW-1:0]  word_cap_o,
   output logic           reconf_o
);

   logic [CHW-1:0] norm;
   logic [CHW-1:0] chans_q;
   int             sh;

   // out-of-range counts fold onto the widest frame
   always_comb begin
      if (cfg_chans_i == '0 || int'(cfg_chans_i) > MAX_CH)
         norm = CHW'(MAX_CH);
      else
         norm = cfg_chans_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         chans_q <= CHW'(MAX_CH);
      else
         chans_q <= norm;
   end

   // partition size rounds the channel count up to a power of two
   always_comb begin
      sh = 0;
      for (int k = 0; k < CHW; k++) begin
         if ((32'd1 << k) < 32'(chans_q))
            sh = k + 1;
      end
   end

   assign chans_o     = chans_q;
   assign frame_cap_o = CW'(DEPTH >> sh);
   assign word_cap_o  = CW'((DEPTH >> sh) * int'(chans_q));
   assign reconf_o    = (norm != chans_q);

endmodule

// File: rtl/tx_sample_fifo_store.sv
module tx_sample_fifo_store #(
   parameter int DW    = 24,
   parameter int DEPTH = 256,
   parameter int AW    = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush_i,
   input  logic          push_i,
   input  logic [DW-1:0] push_data_i,
   input  logic          pop_i,
   output logic [DW-1:0] head_o
);

   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wp, rp, wp_nx, rp_nx;

   generate
      if ((1 << AW) == DEPTH) begin : g_pow2_wrap
         assign wp_nx = wp + 1'b1;
         assign rp_nx = rp + 1'b1;
      end else begin : g_cmp_wrap
         assign wp_nx = (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
         assign rp_nx = (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (push_i)
         mem[wp] <= push_data_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp <= '0;
         rp <= '0;
      end else if (flush_i) begin
         wp <= '0;
         rp <= '0;
      end else begin
         if (push_i) wp <= wp_nx;
         if (pop_i)  rp <= rp_nx;
      end
   end

   assign head_o = mem[rp];

endmodule

// File: rtl/tx_sample_fifo_level.sv
module tx_sample_fifo_level #(
   parameter int CW  = 9,
   parameter int CHW = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           flush_i,
   input  logic           push_i,
   input  logic           pop_i,
   input  logic [CHW-1:0] chans_i,
   input  logic [CW-1:0]  word_cap_i,
   output logic [CW-1:0]  words_o,
   output logic [CW-1:0]  frames_o,
   output logic           full_o,
   output logic           empty_o
);

   logic [CHW-1:0] wr_slot, rd_slot, last_slot;
   logic           wr_done, rd_done;

   assign last_slot = chans_i - 1'b1;
   assign wr_done   = push_i && (wr_slot == last_slot);
   assign rd_done   = pop_i  && (rd_slot == last_slot);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_slot  <= '0;
         rd_slot  <= '0;
         words_o  <= '0;
         frames_o <= '0;
      end else if (flush_i) begin
         wr_slot  <= '0;
         rd_slot  <= '0;
         words_o  <= '0;
         frames_o <= '0;
      end else begin
         if (push_i) wr_slot <= wr_done ? '0 : wr_slot + 1'b1;
         if (pop_i)  rd_slot <= rd_done ? '0 : rd_slot + 1'b1;
         words_o  <= words_o + CW'(push_i) - CW'(pop_i);
         frames_o <= frames_o + CW'(wr_done) - CW'(rd_done);
      end
   end

   assign full_o  = (words_o == word_cap_i);
   assign empty_o = (words_o == '0);

endmodule

// File: rtl/tx_sample_fifo.sv
module tx_sample_fifo
   import tx_sample_fifo_pkg::*;
#(
   parameter int MAX_CH   = 8,
   parameter int DEPTH    = 256,
   parameter int SAMPLE_W = 24,
   parameter int BUS_W    = 32,
   parameter int CHW      = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [CHW-1:0]      cfg_chans,
   input  logic                reg_we,
   input  logic [1:0]          reg_addr,
   input  logic [BUS_W-1:0]    reg_wdata,
   output logic [BUS_W-1:0]    reg_rdata,
   input  logic                pop_i,
   output logic [SAMPLE_W-1:0] pop_data_o,
   output logic                pop_valid_o,
   output logic                irq_o
);

   localparam int AW = $clog2(DEPTH);
   localparam int CW = AW + 1;

   generate
      if (DEPTH < (1 << $clog2(MAX_CH))) begin : g_err_depth
         $error("array too shallow for the channel maximum");
      end
      if (CW > OCC_W) begin : g_err_occ
         $error("occupancy does not fit its status field");
      end
      if (SAMPLE_W >= BUS_W || BUS_W <= HALF_IE_BIT) begin : g_err_bus
         $error("bus too narrow for sample or control fields");
      end
      if (CHW < $clog2(MAX_CH + 1)) begin : g_err_chw
         $error("channel count port too narrow");
      end
   endgenerate

   reg_sel_e       sel;
   logic           ctrl_wr, stat_wr, data_wr;
   logic           flush, reconf, push, pop_ok;
   logic           full, empty;
   logic           ie_q, over_q, under_q;
   logic [CHW-1:0] chans;
   logic [CW-1:0]  frame_cap, word_cap, words, frames;
   logic [SAMPLE_W-1:0] head;
   logic           unused_hi;

   assign sel     = reg_sel_e'(reg_addr);
   assign ctrl_wr = reg_we && (sel == SEL_CTRL);
   assign stat_wr = reg_we && (sel == SEL_STAT);
   assign data_wr = reg_we && (sel == SEL_DATA);

   // sample bits above the stored width are dropped
   assign unused_hi = ^reg_wdata[BUS_W-1:SAMPLE_W];

   tx_sample_fifo_chcfg #(
      .MAX_CH (MAX_CH),
      .DEPTH  (DEPTH),
      .CHW    (CHW),
      .CW     (CW)
   ) u_chcfg (
      .clk         (clk),
      .rst_n       (rst_n),
      .cfg_chans_i (cfg_chans),
      .chans_o     (chans),
      .frame_cap_o (frame_cap),
      .word_cap_o  (word_cap),
      .reconf_o    (reconf)
   );

   assign flush  = (ctrl_wr && reg_wdata[CLR_BIT]) || reconf;
   assign push   = data_wr && !full && !flush;
   assign pop_ok = pop_i && !empty && !flush;

   tx_sample_fifo_store #(
      .DW    (SAMPLE_W),
      .DEPTH (DEPTH),
      .AW    (AW)
   ) u_store (
      .clk         (clk),
      .rst_n       (rst_n),
      .flush_i     (flush),
      .push_i      (push),
      .push_data_i (reg_wdata[SAMPLE_W-1:0]),
      .pop_i       (pop_ok),
      .head_o      (head)
   );

   tx_sample_fifo_level #(
      .CW  (CW),
      .CHW (CHW)
   ) u_level (
      .clk        (clk),
      .rst_n      (rst_n),
      .flush_i    (flush),
      .push_i     (push),
      .pop_i      (pop_ok),
      .chans_i    (chans),
      .word_cap_i (word_cap),
      .words_o    (words),
      .frames_o   (frames),
      .full_o     (full),
      .empty_o    (empty)
   );

   // enable and sticky flags; a new error wins over a same-cycle clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ie_q    <= 1'b0;
         over_q  <= 1'b0;
         under_q <= 1'b0;
      end else begin
         if (ctrl_wr)
            ie_q <= reg_wdata[HALF_IE_BIT];
         over_q  <= (data_wr && full && !flush) ||
                    (over_q && !(stat_wr && reg_wdata[OVER_BIT]));
         under_q <= (pop_i && empty && !flush) ||
                    (under_q && !(stat_wr && reg_wdata[UNDER_BIT]));
      end
   end

   always_comb begin
      reg_rdata = '0;
      unique case (sel)
         SEL_CTRL: reg_rdata[HALF_IE_BIT] = ie_q;
         SEL_STAT: begin
            reg_rdata[OCC_LSB +: OCC_W] = OCC_W'(frames);
            reg_rdata[OVER_BIT]         = over_q;
            reg_rdata[UNDER_BIT]        = under_q;
         end
         default: reg_rdata = '0;
      endcase
   end

   assign pop_valid_o = !empty;
   assign pop_data_o  = empty ? '0 : head;
   assign irq_o       = ie_q && (frames <= (frame_cap >> 1));

endmodule

// File: rtl/tx_sample_fifo_chk.sv
module tx_sample_fifo_chk
   import tx_sample_fifo_pkg::*;
#(
   parameter int CW    = 9,
   parameter int BUS_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             reg_we,
   input logic [1:0]       reg_addr,
   input logic [BUS_W-1:0] reg_wdata,
   input logic             pop_i,
   input logic             pop_valid_o,
   input logic             irq_o,
   input logic             full,
   input logic             flush,
   input logic             reconf,
   input logic             ie_q,
   input logic             over_q,
   input logic             under_q,
   input logic [CW-1:0]    words,
   input logic [CW-1:0]    frames,
   input logic [CW-1:0]    word_cap,
   input logic [CW-1:0]    frame_cap
);

   logic data_wr, stat_wr, ctrl_wr, unused_bits;
   assign data_wr = reg_we && (reg_addr == SEL_DATA);
   assign stat_wr = reg_we && (reg_addr == SEL_STAT);
   assign ctrl_wr = reg_we && (reg_addr == SEL_CTRL);
   assign unused_bits = ^reg_wdata;

   assert_word_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
      words <= word_cap);

   assert_frame_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
      frames <= frame_cap);

   assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (data_wr && full && !flush && !pop_i) |=> ($stable(words) && over_q));

   assert_underrun_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_i && !pop_valid_o && !flush && !data_wr) |=> (under_q && words == '0));

   assert_over_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (over_q && !(stat_wr && reg_wdata[OVER_BIT])) |=> over_q);

   assert_under_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (under_q && !(stat_wr && reg_wdata[UNDER_BIT])) |=> under_q);

   assert_clear_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && reg_wdata[CLR_BIT]) |=> (words == '0 && frames == '0 && !pop_valid_o));

   assert_reconf_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
      reconf |=> (words == '0 && !pop_valid_o));

   assert_irq_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> ie_q);

endmodule

bind tx_sample_fifo tx_sample_fifo_chk #(
   .CW    (CW),
   .BUS_W (BUS_W)
) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .reg_we      (reg_we),
   .reg_addr    (reg_addr),
   .reg_wdata   (reg_wdata),
   .pop_i       (pop_i),
   .pop_valid_o (pop_valid_o),
   .irq_o       (irq_o),
   .full        (full),
   .flush       (flush),
   .reconf      (reconf),
   .ie_q        (ie_q),
   .over_q      (over_q),
   .under_q     (under_q),
   .words       (words),
   .frames      (frames),
   .word_cap    (word_cap),
   .frame_cap   (frame_cap)
);

// File: tb/test_tx_sample_fifo.sv
module test_tx_sample_fifo;
   timeunit 1ns;
   timeprecision 100ps;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [3:0]  cfg_chans;
   logic        reg_we;
   logic [1:0]  reg_addr;
   logic [31:0] reg_wdata;
   logic [31:0] reg_rdata;
   logic        pop_i;
   logic [23:0] pop_data_o;
   logic        pop_valid_o;
   logic        irq_o;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   tx_sample_fifo i_tx_sample_fifo (
      .clk         (clk),
      .rst_n       (rst_n),
      .cfg_chans   (cfg_chans),
      .reg_we      (reg_we),
      .reg_addr    (reg_addr),
      .reg_wdata   (reg_wdata),
      .reg_rdata   (reg_rdata),
      .pop_i       (pop_i),
      .pop_data_o  (pop_data_o),
      .pop_valid_o (pop_valid_o),
      .irq_o       (irq_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // all tasks start and end just after a falling edge
   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      reg_addr  = a;
      reg_wdata = d;
      reg_we    = 1'b1;
      @(negedge clk);
      reg_we    = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] v);
      reg_addr = a;
      #1;
      v = reg_rdata;
   endtask

   task automatic pop_one(output logic [23:0] v);
      pop_i = 1'b1;
      #1;
      v = pop_data_o;
      @(negedge clk);
      pop_i = 1'b0;
   endtask

   function automatic int cap_of(input int e);
      if (e == 1)      return 256;
      else if (e == 2) return 128;
      else if (e <= 4) return 64;
      else             return 32;
   endfunction

   function automatic logic [31:0] pat(input int n, input int i);
      return 32'hA500_0000 | (32'(n) << 16) | 32'(i);
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      logic [23:0] d;
      int cfgs [11] = '{1, 2, 3, 4, 5, 6, 7, 8, 0, 9, 15};
      rst_n = 1'b0; cfg_chans = 4'd1; reg_we = 1'b0; reg_addr = 2'd0;
      reg_wdata = '0; pop_i = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R11 reset state
      rd(2'd1, v); chk("R11 status", v, 32'h0);
      rd(2'd0, v); chk("R11 control", v, 32'h0);
      chk("R11 irq", {31'b0, irq_o}, 32'h0);
      chk("R11 valid", {31'b0, pop_valid_o}, 32'h0);
      chk("R11 data", {8'b0, pop_data_o}, 32'h0);

      for (int c = 0; c < 11; c++) begin
         int n, e, fc, wc, occ;
         n  = cfgs[c];
         e  = (n == 0 || n > 8) ? 8 : n;
         fc = cap_of(e);
         wc = fc * e;
         cfg_chans = 4'(n);
         @(negedge clk);
         wr(2'd0, 32'h0010_0000);
         rd(2'd0, v); chk("R10 enable readback", v, 32'h0010_0000);
         chk("R10 irq empty", {31'b0, irq_o}, 32'h1);
         for (int i = 0; i < wc; i++) begin
            wr(2'd2, pat(n, i));
            occ = (i + 1) / e;
            rd(2'd1, v);
            chk("R4 occupancy fill", {23'b0, v[16:8]}, 32'(occ));
            chk("R10 irq fill", {31'b0, irq_o}, (occ <= fc / 2) ? 32'h1 : 32'h0);
         end
         rd(2'd1, v);
         chk("R1 no overrun at capacity", {31'b0, v[4]}, 32'h0);
         chk("R1 full occupancy", {23'b0, v[16:8]}, 32'(fc));
         wr(2'd2, 32'hDEAD_BEEF);
         rd(2'd1, v);
         chk("R5 overrun flag", {31'b0, v[4]}, 32'h1);
         chk("R5 occupancy kept", {23'b0, v[16:8]}, 32'(fc));
         for (int i = 0; i < wc; i++) begin
            pop_one(d);
            chk("R3 order and width", {8'b0, d}, pat(n, i) & 32'h00FF_FFFF);
            occ = fc - (i + 1) / e;
            chk("R10 irq drain", {31'b0, irq_o}, (occ <= fc / 2) ? 32'h1 : 32'h0);
         end
         chk("R5 extra word dropped", {31'b0, pop_valid_o}, 32'h0);
         chk("R3 empty data zero", {8'b0, pop_data_o}, 32'h0);
         pop_one(d);
         rd(2'd1, v);
         chk("R6 underrun flags", v, 32'h11);
         wr(2'd1, 32'h0);
         rd(2'd1, v); chk("R7 zero write keeps", v, 32'h11);
         wr(2'd1, 32'h1);
         rd(2'd1, v); chk("R7 clear underrun", v, 32'h10);
         wr(2'd1, 32'h10);
         rd(2'd1, v); chk("R7 clear overrun", v, 32'h0);
         wr(2'd0, 32'h0);
         chk("R10 irq disabled", {31'b0, irq_o}, 32'h0);
      end

      // R8 clear with enable written in the same access
      cfg_chans = 4'd2;
      @(negedge clk);
      for (int i = 0; i < 5; i++) wr(2'd2, 32'(i + 100));
      rd(2'd1, v); chk("R4 two frames", {23'b0, v[16:8]}, 32'd2);
      wr(2'd0, 32'h0010_0001);
      rd(2'd1, v); chk("R8 cleared occupancy", v, 32'h0);
      chk("R8 cleared valid", {31'b0, pop_valid_o}, 32'h0);
      rd(2'd0, v); chk("R8 clear bit self-clears", v, 32'h0010_0000);
      wr(2'd2, 32'h0000_0777);
      pop_one(d); chk("R8 fresh after clear", {8'b0, d}, 32'h777);
      wr(2'd0, 32'h0);

      // R9 channel change empties
      for (int i = 0; i < 4; i++) wr(2'd2, 32'(i));
      cfg_chans = 4'd3;
      @(negedge clk);
      rd(2'd1, v); chk("R9 occupancy after change", v, 32'h0);
      chk("R9 valid after change", {31'b0, pop_valid_o}, 32'h0);

      // R4 partial frame is not counted
      wr(2'd2, 32'h11); wr(2'd2, 32'h22);
      rd(2'd1, v); chk("R4 partial frame", {23'b0, v[16:8]}, 32'h0);
      chk("R4 partial valid", {31'b0, pop_valid_o}, 32'h1);

      // R2 same effective count keeps contents
      cfg_chans = 4'd8;
      @(negedge clk);
      for (int i = 0; i < 8; i++) wr(2'd2, 32'(i + 40));
      cfg_chans = 4'd9;
      @(negedge clk);
      rd(2'd1, v); chk("R2 no flush 8 to 9", {23'b0, v[16:8]}, 32'h1);
      pop_one(d); chk("R2 head kept", {8'b0, d}, 32'd40);

      // select 3 reads zero
      rd(2'd3, v); chk("R3 unused select", v, 32'h0);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule